// File: doc/BRIEF.md
# Flash Bulk Transfer FIFO Engine

This block sits between a host register port and a word-wide flash port and moves bulk data through one 32-bit FIFO. The host loads a flash address, then writes a control word that carries a read-mode flag and a word count. The engine fetches that many words from flash into the FIFO, keeping one request outstanding at a time, and drops its busy flag once the last word has landed. The host then pops the words from the FIFO data port. Writing zero to the control word ends the operation.

For writes, the host pushes words into the same FIFO port while read mode is off. The engine drains them to the flash write port, one word per cycle whenever the flash is ready, with the address stepping by 4 for each word. The host paces its blocks by reading the free-space field of the control word and waiting until it shows the whole FIFO free. A trailing partial word occupies one full FIFO word. Reading an empty FIFO and writing a full one are both recorded in sticky flags.

Top module: `flash_xfer_engine`

## Requirements
- R1: After reset the control word reads as free space equal to DEPTH in bits [15:8] with all flag bits clear, and the address register reads zero.
- R2: An accepted control write with bit 0 set and a non-zero count in bits [31:16] sets busy (bit 1) and issues that many flash reads, one outstanding at a time, at addresses A, A+4, A+8 and so on, A being the loaded address.
- R3: Busy clears once the final requested word is in the FIFO, and the FIFO then returns the fetched words in request order.
- R4: A count above DEPTH is clamped to DEPTH; a count of zero leaves busy clear.
- R5: Each host read of the FIFO port (offset 2) pops one word and raises the free space by one.
- R6: Each host write of the FIFO port pushes one word while read mode is clear; queued words go to the flash write port one per cycle while it is ready, at the loaded address plus 4 per word.
- R7: The free-space field always equals DEPTH minus the number of words held.
- R8: Reading the FIFO port while the FIFO is empty returns zero and sets the sticky underflow bit (bit 2).
- R9: Writing the FIFO port while it is full drops the word and sets the sticky overflow bit (bit 3).
- R10: Control writes, and address register writes, made while busy is set are ignored.
- R11: An accepted control write of zero clears read mode (bit 0) and both sticky flags.
- R12: While read mode is set, host writes of the FIFO port are ignored and nothing is sent to the flash write port.
- R13: The address register (offset 1) reads back the current flash pointer, which steps by 4 for each flash word read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 control, 1 address, 2 FIFO |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the strobe cycle |
| flash_rd_req | output | 1 | Flash read request, one cycle |
| flash_rd_addr | output | 32 | Flash read address |
| flash_rd_valid | input | 1 | Flash read data valid |
| flash_rd_data | input | 32 | Flash read data |
| flash_wr_valid | output | 1 | Flash write word offered |
| flash_wr_addr | output | 32 | Flash write address |
| flash_wr_data | output | 32 | Flash write data |
| flash_wr_ready | input | 1 | Flash accepts the offered word |

## Verification
Host read data is combinational, so the bench samples it one time step after driving a read strobe on the falling edge; every register effect of a write or pop is due at the rising edge that follows and is read back on the next falling edge. A flash read request is answered by the bench model one falling edge later, so each fetched word enters the FIFO two rising edges after its request, and busy is polled rather than counted to absorb that latency. Drained flash writes are compared word by word as they are accepted, and their cycle stamps confirm one word per cycle.

// File: rtl/fxe_pkg.sv
package fxe_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_FIFO = 2'd2;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_t;

  function automatic int unsigned clamp_count(int unsigned req, int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

  function automatic int unsigned free_words(int unsigned depth, int unsigned held);
    return depth - held;
  endfunction

  function automatic logic [31:0] step_addr(logic [31:0] a);
    return a + 32'd4;
  endfunction
endpackage

// File: rtl/fxe_fifo.sv
module fxe_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_push_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/fxe_rd_seq.sv
module fxe_rd_seq #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_cnt,
  input  logic          fifo_full,
  input  logic          rd_valid,
  output logic          rd_req,
  output logic          seq_push,
  output logic          busy
);
  import fxe_pkg::*;
  seq_state_t    state;
  logic [CW-1:0] remaining;

  assign busy     = (state != SEQ_IDLE);
  assign rd_req   = (state == SEQ_ISSUE) && !fifo_full;
  assign seq_push = (state == SEQ_WAIT) && rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      remaining <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          remaining <= start_cnt;
          state     <= SEQ_ISSUE;
        end
        SEQ_ISSUE: if (!fifo_full) state <= SEQ_WAIT;
        SEQ_WAIT: if (rd_valid) begin
          remaining <= remaining - 1'b1;
          state     <= (remaining == CW'(1)) ? SEQ_IDLE : SEQ_ISSUE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/fxe_wr_drain.sv
module fxe_wr_drain #(
  parameter int W = 32
) (
  input  logic         enable,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_dout,
  input  logic         wr_ready,
  output logic         wr_valid,
  output logic [W-1:0] wr_data,
  output logic         drain_pop
);
  assign wr_valid  = enable && !fifo_empty;
  assign wr_data   = fifo_dout;
  assign drain_pop = wr_valid && wr_ready;
endmodule

// File: rtl/flash_xfer_engine.sv
module flash_xfer_engine #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        flash_rd_req,
  output logic [31:0] flash_rd_addr,
  input  logic        flash_rd_valid,
  input  logic [31:0] flash_rd_data,
  output logic        flash_wr_valid,
  output logic [31:0] flash_wr_addr,
  output logic [31:0] flash_wr_data,
  input  logic        flash_wr_ready
);
  import fxe_pkg::*;

  logic          rd_mode, udf, ovf, busy;
  logic [31:0]   ptr;
  logic          ctrl_wr, ctrl_accept, ctrl_zero, addr_wr, start;
  logic          host_push, host_pop, seq_push, drain_pop, drain_en;
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0]   fifo_din, fifo_dout;
  logic [CW-1:0] fifo_count, start_cnt, free_cnt;

  assign ctrl_wr     = host_wr && (host_addr == REG_CTRL);
  assign ctrl_accept = ctrl_wr && !busy;
  assign ctrl_zero   = ctrl_accept && (host_wdata == '0);
  assign addr_wr     = host_wr && (host_addr == REG_ADDR) && !busy;
  assign start_cnt   = CW'(clamp_count(int'(host_wdata[31:16]), DEPTH));
  assign start       = ctrl_accept && host_wdata[0] && (start_cnt != '0);
  assign host_push   = host_wr && (host_addr == REG_FIFO) && !rd_mode;
  assign host_pop    = host_rd && (host_addr == REG_FIFO);
  assign drain_en    = !rd_mode && !host_pop;
  assign fifo_push   = seq_push || host_push;
  assign fifo_pop    = host_pop || drain_pop;
  assign fifo_din    = seq_push ? flash_rd_data : host_wdata;
  assign free_cnt    = CW'(free_words(DEPTH, int'(fifo_count)));

  fxe_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop), .din(fifo_din),
    .dout(fifo_dout), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  fxe_rd_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(start_cnt),
    .fifo_full(fifo_full), .rd_valid(flash_rd_valid), .rd_req(flash_rd_req),
    .seq_push(seq_push), .busy(busy)
  );

  fxe_wr_drain #(.W(32)) u_drain (
    .enable(drain_en), .fifo_empty(fifo_empty), .fifo_dout(fifo_dout),
    .wr_ready(flash_wr_ready), .wr_valid(flash_wr_valid), .wr_data(flash_wr_data),
    .drain_pop(drain_pop)
  );

  assign flash_rd_addr = ptr;
  assign flash_wr_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mode <= 1'b0;
      udf     <= 1'b0;
      ovf     <= 1'b0;
      ptr     <= '0;
    end else begin
      if (ctrl_accept) rd_mode <= host_wdata[0];
      if (ctrl_zero) begin
        udf <= 1'b0;
        ovf <= 1'b0;
      end else begin
        if (host_pop && fifo_empty) udf <= 1'b1;
        if (host_push && fifo_full && !drain_pop) ovf <= 1'b1;
      end
      if (addr_wr) ptr <= host_wdata;
      else if (flash_rd_req || drain_pop) ptr <= step_addr(ptr);
    end
  end

  always_comb begin
    case (host_addr)
      REG_CTRL: host_rdata = {16'h0, 8'(free_cnt), 4'h0, ovf, udf, busy, rd_mode};
      REG_ADDR: host_rdata = ptr;
      REG_FIFO: host_rdata = fifo_empty ? 32'h0 : fifo_dout;
      default:  host_rdata = 32'h0;
    endcase
  end

  assert_busy_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_mode);
  assert_ctrl_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> rd_mode);
  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && fifo_empty && !ctrl_zero) |=> udf);
  assert_no_drain_in_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |-> !flash_wr_valid);
  assert_addr_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rd_req && !addr_wr) |=> (ptr == $past(ptr) + 32'd4));
  assert_push_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_push && host_push));
endmodule

// File: tb/flash_xfer_engine_tb.sv
module flash_xfer_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = 32'h0, host_rdata;
  logic        flash_rd_req, flash_rd_valid = 1'b0;
  logic [31:0] flash_rd_addr, flash_rd_data = 32'h0;
  logic        flash_wr_valid, flash_wr_ready = 1'b0;
  logic [31:0] flash_wr_addr, flash_wr_data;

  int ntests = 0, nfail = 0, cyc = 0;
  int rcnt = 0, wcnt = 0, wfill = 0, wfirst = 0, wlast = 0;
  logic [31:0] rbase = 0, lat_addr = 0;
  int lat = 0;
  logic [31:0] exp_wd [64];
  logic [31:0] exp_wa [64];

  always #(CLK_P/2) clk = ~clk;

  flash_xfer_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .flash_rd_req(flash_rd_req), .flash_rd_addr(flash_rd_addr),
    .flash_rd_valid(flash_rd_valid), .flash_rd_data(flash_rd_data),
    .flash_wr_valid(flash_wr_valid), .flash_wr_addr(flash_wr_addr),
    .flash_wr_data(flash_wr_data), .flash_wr_ready(flash_wr_ready)
  );

  function automatic logic [31:0] fdata(logic [31:0] a);
    return {a[15:0], a[15:0] ^ 16'h5A3C};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle(output logic [31:0] c);
    for (int i = 0; i < 200; i++) begin
      hread(2'd0, c);
      if (!c[1]) break;
    end
  endtask

  // flash model and monitors, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    flash_rd_valid = 1'b0;
    if (lat == 1) begin
      flash_rd_valid = 1'b1;
      flash_rd_data  = fdata(lat_addr);
      lat = 0;
    end
    if (flash_rd_req) begin
      chk(flash_rd_addr == rbase + 32'(4 * rcnt), "R2 read address", flash_rd_addr, rbase + 32'(4 * rcnt));
      lat_addr = flash_rd_addr;
      lat = 1;
      rcnt++;
    end
    if (flash_wr_valid && flash_wr_ready) begin
      chk(flash_wr_data == exp_wd[wcnt], "R6 write data", flash_wr_data, exp_wd[wcnt]);
      chk(flash_wr_addr == exp_wa[wcnt], "R6 write address", flash_wr_addr, exp_wa[wcnt]);
      if (wcnt == wfirst) wlast = cyc;
      wcnt++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int eff, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(2'd0, d);
    chk(d == 32'(DEPTH << 8), "R1 ctrl after reset", d, 32'(DEPTH << 8));
    hread(2'd1, d);
    chk(d == 32'h0, "R1 address after reset", d, 32'h0);

    // R9 overflow with flash stalled, then R6 drain
    hwrite(2'd1, 32'h100);
    for (int i = 0; i <= DEPTH; i++) begin
      if (i < DEPTH) begin
        exp_wd[wfill] = 32'hC0DE0000 + 32'(i);
        exp_wa[wfill] = 32'h100 + 32'(4 * i);
        wfill++;
      end
      hwrite(2'd2, 32'hC0DE0000 + 32'(i));
    end
    hread(2'd0, d);
    chk(d[15:8] == 8'd0, "R7 free space when full", {24'h0, d[15:8]}, 32'h0);
    chk(d[3] == 1'b1, "R9 overflow flag", {31'h0, d[3]}, 32'h1);
    chk(wcnt == 0, "R6 no write while not ready", 32'(wcnt), 32'h0);
    wfirst = 0;
    @(negedge clk);
    flash_wr_ready = 1'b1;
    t0 = cyc;
    repeat (DEPTH + 3) @(negedge clk);
    chk(wcnt == DEPTH, "R9 dropped word not written", 32'(wcnt), 32'(DEPTH));
    chk(wlast - t0 == 1, "R6 first drain cycle", 32'(wlast - t0), 32'h1);
    hread(2'd0, d);
    chk(d[15:8] == 8'(DEPTH), "R7 free after drain", {24'h0, d[15:8]}, 32'(DEPTH));
    chk(d[3] == 1'b1, "R9 overflow sticky", {31'h0, d[3]}, 32'h1);
    hread(2'd1, d);
    chk(d == 32'h100 + 32'(4 * DEPTH), "R13 address after writes", d, 32'h100 + 32'(4 * DEPTH));
    hwrite(2'd0, 32'h0);
    hread(2'd0, d);
    chk(d[3:0] == 4'h0, "R11 flags cleared", {28'h0, d[3:0]}, 32'h0);

    // R6 streaming with ready high: each word drained
    hwrite(2'd1, 32'h200);
    for (int i = 0; i < 5; i++) begin
      exp_wd[wfill] = 32'hBEEF0000 + 32'(i);
      exp_wa[wfill] = 32'h200 + 32'(4 * i);
      wfill++;
      hwrite(2'd2, 32'hBEEF0000 + 32'(i));
    end
    repeat (3) @(negedge clk);
    chk(wcnt == wfill, "R6 streamed words written", 32'(wcnt), 32'(wfill));

    // R2 R3 R4 R5 read sweep over counts 0..DEPTH+2
    for (int n = 0; n <= DEPTH + 2; n++) begin
      eff = (n > DEPTH) ? DEPTH : n;
      rbase = 32'h1000 + 32'(n * 256);
      rcnt = 0;
      hwrite(2'd1, rbase);
      hwrite(2'd0, {16'(n), 16'h0001});
      hread(2'd0, d);
      if (eff == 0) begin
        chk(d[1:0] == 2'b01, "R4 zero count not busy", {30'h0, d[1:0]}, 32'h1);
      end else begin
        chk(d[1] == 1'b1, "R2 busy after start", {31'h0, d[1]}, 32'h1);
        if (n == DEPTH) begin
          hwrite(2'd0, 32'h0);
          hwrite(2'd1, 32'hFFFF0000);
        end
        wait_idle(d);
        chk(d[1:0] == 2'b01, "R3 busy cleared, mode held (R10)", {30'h0, d[1:0]}, 32'h1);
      end
      chk(rcnt == eff, "R4 request count", 32'(rcnt), 32'(eff));
      chk(d[15:8] == 8'(DEPTH - eff), "R7 free after read", {24'h0, d[15:8]}, 32'(DEPTH - eff));
      hread(2'd1, d);
      chk(d == rbase + 32'(4 * eff), "R13 address after read", d, rbase + 32'(4 * eff));
      if (n == 3) begin
        hwrite(2'd2, 32'hDEADDEAD);
        repeat (2) @(negedge clk);
        hread(2'd0, d);
        chk(d[15:8] == 8'(DEPTH - eff), "R12 push ignored in read mode", {24'h0, d[15:8]}, 32'(DEPTH - eff));
        chk(wcnt == wfill, "R12 no flash write in read mode", 32'(wcnt), 32'(wfill));
      end
      for (int i = 0; i < eff; i++) begin
        hread(2'd2, d);
        chk(d == fdata(rbase + 32'(4 * i)), "R3 FIFO order", d, fdata(rbase + 32'(4 * i)));
        hread(2'd0, d);
        chk(d[15:8] == 8'(DEPTH - eff + i + 1), "R5 pop frees one", {24'h0, d[15:8]}, 32'(DEPTH - eff + i + 1));
      end
      hwrite(2'd0, 32'h0);
      hread(2'd0, d);
      chk(d == 32'(DEPTH << 8), "R11 ctrl after end", d, 32'(DEPTH << 8));
    end

    // R8 underflow
    hread(2'd2, d);
    chk(d == 32'h0, "R8 empty read value", d, 32'h0);
    hread(2'd0, d);
    chk(d[2] == 1'b1, "R8 underflow flag", {31'h0, d[2]}, 32'h1);
    hwrite(2'd0, 32'h0);
    hread(2'd0, d);
    chk(d[2] == 1'b0, "R11 underflow cleared", {31'h0, d[2]}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule